// File: doc/BRIEF.md
# Segmented Address Generation Unit

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical memory address. It holds four segment registers: code, data, stack and extra. Each memory request carries a reference-kind code, a flag that says whether the base register is the frame pointer, and an optional segment override. Fixed rules pick the segment from these inputs. The result is the segment shifted left by four bits plus the offset, with the carry out of bit 19 dropped.

The same request port also forms I/O port addresses. The port number comes either from an 8-bit immediate, which is zero-extended, or from a 16-bit register value, which is used as it is. Ports in the range 00F8h to 00FFh raise a reserved flag. The address, the chosen segment code and the flags are registered, and they appear one clock after the request together with a valid strobe. A write port loads the segment registers.

Top module: `seg_agu_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid` is low. Reset sets the code segment to FFFFh and the data, stack and extra segments to 0000h.
- R2: For a memory request, `out_addr` equals (segment × 16 + offset) mod 2^20. `out_io` and `out_rsvd` are low.
- R3: Reference kind 0 (instruction fetch) selects the code segment. `out_seg` reports 1 and the override has no effect.
- R4: Reference kind 1 (stack push or pop) selects the stack segment. `out_seg` reports 2 and the override has no effect.
- R5: Reference kind 3 (string destination indexed by DI) selects the extra segment. `out_seg` reports 0 and the override has no effect.
- R6: Any other kind (2 = data, 4 = string source, 5 to 7 treated as data) with no override selects the stack segment (`out_seg` 2) when `base_bp` is high. Otherwise it selects the data segment (`out_seg` 3).
- R7: For the kinds covered by R6, when `ovr_en` is high the segment given by `ovr_seg` is used, whatever `base_bp` is. Its code is 0 for extra, 1 for code, 2 for stack and 3 for data.
- R8: An I/O request with `io_use_dx` low gives `out_addr` = `io_port8` zero-extended to 20 bits. `out_io` is high and `out_seg` is 0.
- R9: An I/O request with `io_use_dx` high gives `out_addr` = `dx_value` zero-extended to 20 bits, whatever the offset and segment inputs are.
- R10: `out_rsvd` is high only for I/O requests whose 16-bit port lies in 00F8h to 00FFh.
- R11: A segment write with `wr_en` takes effect at the next clock edge. The index uses the same codes as R7. A request in the same cycle as the write still uses the old value.
- R12: Results appear exactly one clock after `req_valid`. `out_valid` is low in every cycle after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Segment register write enable |
| wr_idx | input | 2 | Segment register index (0 extra, 1 code, 2 stack, 3 data) |
| wr_data | input | 16 | Segment write value |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 3 | Reference kind code |
| req_offset | input | 16 | Memory offset |
| base_bp | input | 1 | Frame pointer is the base register |
| ovr_en | input | 1 | Segment override request |
| ovr_seg | input | 2 | Override segment code |
| io_sel | input | 1 | Request is an I/O access |
| io_use_dx | input | 1 | Take the port from `dx_value` rather than `io_port8` |
| io_port8 | input | 8 | Immediate port number |
| dx_value | input | 16 | Register port number |
| out_valid | output | 1 | Result strobe |
| out_addr | output | 20 | Physical or port address |
| out_seg | output | 2 | Selected segment code |
| out_io | output | 1 | Result is an I/O address |
| out_rsvd | output | 1 | Reserved port accessed |

## Verification
The selection rules are tried over every combination of reference kind, base-pointer flag, override enable and override code. These sweeps separate the kinds that must ignore the override from those that must obey it, and they show where `base_bp` matters. The segment values are chosen to be distinct, and the offsets include 0, FFFFh and values that carry past bit 19, so a wrong segment, a wrong shift or a missing wrap shows up in the address. All 256 immediate ports and a run of register ports from 0000h to 0200h are applied, together with high ports that end in F8h–FFh. These show the exact edges of the reserved window and whether the two port sources are kept apart. Back-to-back writes and requests show the one-cycle write latency.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;

    localparam int NUM_SEG   = 4;
    localparam int SEG_IDX_W = $clog2(NUM_SEG);
    localparam int KIND_W    = 3;

    typedef enum logic [SEG_IDX_W-1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_code_e;

    typedef enum logic [KIND_W-1:0] {
        REF_FETCH   = 3'd0,
        REF_STACK   = 3'd1,
        REF_DATA    = 3'd2,
        REF_STR_DST = 3'd3,
        REF_STR_SRC = 3'd4
    } ref_kind_e;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_agu_pkg::*;
#(
    parameter int          SEG_W   = 16,
    parameter logic [15:0] CS_RSTV = 16'hFFFF
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [SEG_IDX_W-1:0]               wr_idx,
    input  logic [SEG_W-1:0]                   wr_data,
    output logic [NUM_SEG-1:0][SEG_W-1:0]      seg_o
);

    logic [NUM_SEG-1:0][SEG_W-1:0] seg_d;
    logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;

    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
        always_comb begin
            seg_d[i] = seg_q[i];
            if (wr_en && (wr_idx == SEG_IDX_W'(i))) begin
                seg_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SEG; i++) begin
                seg_q[i] <= (i == int'(SEG_CS)) ? SEG_W'(CS_RSTV) : '0;
            end
        end else begin
            seg_q <= seg_d;
        end
    end

    assign seg_o = seg_q;

    // R11
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> seg_q[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/seg_picker.sv
module seg_picker
    import seg_agu_pkg::*;
(
    input  ref_kind_e  kind,
    input  logic       base_bp,
    input  logic       ovr_en,
    input  seg_code_e  ovr_seg,
    output seg_code_e  sel
);

    seg_code_e implied;

    always_comb begin
        implied = base_bp ? SEG_SS : SEG_DS;
        case (kind)
            REF_FETCH:   sel = SEG_CS;
            REF_STACK:   sel = SEG_SS;
            REF_STR_DST: sel = SEG_ES;
            default:     sel = ovr_en ? ovr_seg : implied;
        endcase
    end

endmodule

// File: rtl/io_port_gen.sv
module io_port_gen #(
    parameter int          IO_W    = 16,
    parameter int          P8_W    = 8,
    parameter logic [15:0] RSVD_LO = 16'h00F8,
    parameter logic [15:0] RSVD_HI = 16'h00FF
) (
    input  logic            use_reg,
    input  logic [P8_W-1:0] port8,
    input  logic [IO_W-1:0] port_reg,
    output logic [IO_W-1:0] port,
    output logic            rsvd
);

    localparam int PAD_W = IO_W - P8_W;

    always_comb begin
        port = use_reg ? port_reg : {{PAD_W{1'b0}}, port8};
        rsvd = (port >= IO_W'(RSVD_LO)) && (port <= IO_W'(RSVD_HI));
    end

endmodule

// File: rtl/seg_agu_top.sv
module seg_agu_top
    import seg_agu_pkg::*;
#(
    parameter int SEG_W     = 16,
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int IO_W      = 16,
    parameter int P8_W      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_idx,
    input  logic [15:0]          wr_data,
    input  logic                 req_valid,
    input  logic [2:0]           req_kind,
    input  logic [15:0]          req_offset,
    input  logic                 base_bp,
    input  logic                 ovr_en,
    input  logic [1:0]           ovr_seg,
    input  logic                 io_sel,
    input  logic                 io_use_dx,
    input  logic [7:0]           io_port8,
    input  logic [15:0]          dx_value,
    output logic                 out_valid,
    output logic [19:0]          out_addr,
    output logic [1:0]           out_seg,
    output logic                 out_io,
    output logic                 out_rsvd
);

    localparam int PA_W   = SEG_W + SEG_SHIFT;
    localparam int OPAD_W = PA_W - OFS_W;
    localparam int IPAD_W = PA_W - IO_W;

    typedef struct packed {
        logic                 vld;
        logic [PA_W-1:0]      addr;
        logic [SEG_IDX_W-1:0] seg;
        logic                 io;
        logic                 rsvd;
    } res_t;

    logic [NUM_SEG-1:0][SEG_W-1:0] segs;
    seg_code_e                     pick;
    logic [IO_W-1:0]               port;
    logic                          port_rsvd;
    logic [SEG_W-1:0]              seg_val;
    logic [PA_W-1:0]               mem_addr;
    res_t                          res_d, res_q;

    seg_regfile #(.SEG_W(SEG_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .seg_o   (segs)
    );

    seg_picker u_pick (
        .kind    (ref_kind_e'(req_kind)),
        .base_bp (base_bp),
        .ovr_en  (ovr_en),
        .ovr_seg (seg_code_e'(ovr_seg)),
        .sel     (pick)
    );

    io_port_gen #(.IO_W(IO_W), .P8_W(P8_W)) u_io (
        .use_reg  (io_use_dx),
        .port8    (io_port8),
        .port_reg (dx_value),
        .port     (port),
        .rsvd     (port_rsvd)
    );

    always_comb begin
        seg_val  = segs[pick];
        mem_addr = {seg_val, {SEG_SHIFT{1'b0}}} + {{OPAD_W{1'b0}}, req_offset};

        res_d     = res_q;
        res_d.vld = req_valid;
        if (req_valid) begin
            if (io_sel) begin
                res_d.addr = {{IPAD_W{1'b0}}, port};
                res_d.seg  = '0;
                res_d.io   = 1'b1;
                res_d.rsvd = port_rsvd;
            end else begin
                res_d.addr = mem_addr;
                res_d.seg  = pick;
                res_d.io   = 1'b0;
                res_d.rsvd = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.vld;
    assign out_addr  = res_q.addr;
    assign out_seg   = res_q.seg;
    assign out_io    = res_q.io;
    assign out_rsvd  = res_q.rsvd;

    // R12
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    // R3
    fetch_uses_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !io_sel && req_kind == 3'd0) |=> out_seg == 2'd1);

    // R4
    stack_uses_ss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !io_sel && req_kind == 3'd1) |=> out_seg == 2'd2);

    // R5
    strdst_uses_es_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !io_sel && req_kind == 3'd3) |=> out_seg == 2'd0);

    // R8
    port8_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && io_sel && !io_use_dx) |=> (out_addr[19:8] == '0 && out_io));

    // R9
    dx_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && io_sel && io_use_dx) |=> out_addr == {4'h0, $past(dx_value)});

    // R10
    rsvd_only_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_rsvd) |-> (out_io && out_addr[19:3] == 17'h1F));

endmodule

// File: tb/sim_seg_agu_top.sv
module sim_seg_agu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [15:0] req_offset = '0;
    logic        base_bp = 1'b0;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_seg = '0;
    logic        io_sel = 1'b0;
    logic        io_use_dx = 1'b0;
    logic [7:0]  io_port8 = '0;
    logic [15:0] dx_value = '0;
    logic        out_valid;
    logic [19:0] out_addr;
    logic [1:0]  out_seg;
    logic        out_io;
    logic        out_rsvd;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] model [4];

    always #5 clk = ~clk;

    seg_agu_top u0 (.*);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_code(int kind, bit bp, bit oe, int os);
        case (kind)
            0: return 1;
            1: return 2;
            3: return 0;
            default: return oe ? os : (bp ? 2 : 3);
        endcase
    endfunction

    task automatic wr(input int idx, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 2'(idx); wr_data = 16'(val);
        model[idx] = 16'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic mem_req(input int kind, input bit bp, input bit oe, input int os,
                           input int ofs, input string req);
        int code;
        int exp;
        @(negedge clk);
        req_valid = 1'b1; io_sel = 1'b0; req_kind = 3'(kind); base_bp = bp;
        ovr_en = oe; ovr_seg = 2'(os); req_offset = 16'(ofs);
        @(negedge clk);
        req_valid = 1'b0;
        code = exp_code(kind, bp, oe, os);
        exp  = ((int'(model[code]) << 4) + ofs) & 32'hFFFFF;
        check({req, " valid"}, int'(out_valid), 1);
        check({req, " seg"}, int'(out_seg), code);
        check({req, " addr R2"}, int'(out_addr), exp);
        check({req, " io/rsvd R2"}, int'({out_io, out_rsvd}), 0);
    endtask

    task automatic io_req(input bit use_dx, input int p8, input int dx, input string req);
        int port;
        @(negedge clk);
        req_valid = 1'b1; io_sel = 1'b1; io_use_dx = use_dx;
        io_port8 = 8'(p8); dx_value = 16'(dx);
        req_offset = 16'(dx ^ 16'h5A5A); req_kind = 3'(p8); ovr_en = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        port = use_dx ? (dx & 16'hFFFF) : (p8 & 8'hFF);
        check({req, " addr"}, int'(out_addr), port);
        check({req, " io R8"}, int'({out_valid, out_io, out_seg}), 4'b1100);
        check({req, " rsvd R10"}, int'(out_rsvd), int'(port >= 16'h00F8 && port <= 16'h00FF));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        model[0] = 16'h0000; model[1] = 16'hFFFF; model[2] = 16'h0000; model[3] = 16'h0000;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", int'(out_valid), 0);
        // R1 reset values seen through addresses; R2 wrap at FFFF:FFFF
        mem_req(0, 0, 0, 0, 16'h0000, "R1 cs reset");
        mem_req(0, 0, 0, 0, 16'hFFFF, "R2 wrap");
        mem_req(2, 0, 0, 0, 16'h1234, "R1 ds reset");
        mem_req(1, 0, 0, 0, 16'h0042, "R1 ss reset");
        mem_req(3, 0, 0, 0, 16'h0099, "R1 es reset");
        // R12 idle cycle
        @(negedge clk);
        check("R12 idle", int'(out_valid), 0);

        // R11 write lands next edge; same-cycle request sees old value
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 2'd3; wr_data = 16'h2468;
        req_valid = 1'b1; io_sel = 1'b0; req_kind = 3'd2; base_bp = 1'b0;
        ovr_en = 1'b0; req_offset = 16'h0010;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check("R11 same-cycle old", int'(out_addr), 32'h00010);
        model[3] = 16'h2468;
        mem_req(2, 0, 0, 0, 16'h0010, "R11 new value");

        wr(0, 16'h1234);
        wr(1, 16'hF000);
        wr(2, 16'h8000);
        wr(3, 16'hFFFF);

        // R3 R4 R5 R6 R7 sweep
        for (int k = 0; k < 8; k++)
            for (int b = 0; b < 2; b++)
                for (int e = 0; e < 2; e++)
                    for (int s = 0; s < 4; s++)
                        for (int o = 0; o < 6; o++) begin
                            int ofs;
                            case (o)
                                0: ofs = 16'h0000; 1: ofs = 16'h0001; 2: ofs = 16'h000F;
                                3: ofs = 16'h8000; 4: ofs = 16'hFFFF; default: ofs = 16'h1357;
                            endcase
                            mem_req(k, b[0], e[0], s, ofs, "R3/R4/R5/R6/R7 sel");
                        end

        // R8 immediate ports, R10 edges
        for (int p = 0; p < 256; p++) io_req(1'b0, p, 16'hFFF9, "R8 port8");
        // R9 register ports, R10 window
        for (int d = 0; d <= 16'h0200; d++) io_req(1'b1, d & 8'hFF, d, "R9 dx");
        io_req(1'b1, 8'hF8, 16'hF8F8, "R10 high F8");
        io_req(1'b1, 8'hFC, 16'hFFFC, "R10 high FC");
        io_req(1'b1, 8'h00, 16'hFFFF, "R9 max");
        @(negedge clk);
        check("R12 idle after io", int'(out_valid), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule